// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol engine of a byte-addressed non-volatile memory that sits on a two-wire serial bus as a slave. It runs on a fast system clock and oversamples the bus clock and data lines. It recognises bus start and stop events and matches a device-select byte against three strap pins. A write carries a two-byte word address followed by data bytes. A read returns bytes from an internal byte array, one after another, for as long as the master acknowledges.

Write data first goes into a page buffer. The buffer is committed to the array only when the master ends the transfer with a stop. A timed busy window follows, and during that window the engine answers no device-select byte, so a master can poll for completion. A write-protect input, sampled at the stop, suppresses the commit. The engine drives the data line only as an open-drain pull-down request. The bus wiring outside the block combines that request with the pull-up.

Top module: `twi_eeprom_slave`

## Requirements
- R1: SDA falling while SCL is high (start) opens a new device-select byte from any state, even in the middle of a byte. SDA rising while SCL is high (stop) returns to idle. After either event `sda_pull_o` is 0.
- R2: The first byte after a start is compared bit 7 downto 1 with `{4'b1010, strap_i[2:0]}`. Bit 0 chooses read (1) or write (0). On a mismatch the engine gives no acknowledge and ignores the rest of the transfer.
- R3: After each byte the engine accepts in a write, it acknowledges by holding `sda_pull_o` at 1 through the ninth SCL high phase.
- R4: A write header carries two address bytes, high byte first. Their concatenation, truncated to ADDR_W bits, becomes the word pointer. Higher bits are ignored.
- R5: Each accepted data byte goes to the buffered page at the pointer's low PAGE_W bits, and those bits then increment and wrap within the page. A write of more than 2^PAGE_W bytes therefore overwrites the page's earliest bytes.
- R6: Buffered bytes reach the array only after a stop. A transfer that is cut short before its first complete data byte commits nothing and starts no busy window.
- R7: After a committing stop, the engine acknowledges no device-select byte for BUSY_CYC system cycles. After that it acknowledges again.
- R8: If `wprot_i` is 1 at the stop, the array is left unchanged and no busy window starts. Data bytes are still acknowledged.
- R9: A read with no address first starts at the pointer, which holds the last accessed address plus one. Read addresses wrap from the top of the array to address 0.
- R10: A read keeps sending successive bytes while the master acknowledges. After a master NACK the engine releases SDA and goes idle.
- R11: A write header with only the address, followed by a repeated start and a read-select byte, reads from that address.
- R12: Read data is sent MSB first. The engine changes it only after SCL falls, so it stays stable through each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| strap_i | input | 3 | Device-select strap pins |
| wprot_i | input | 1 | Write protect; 1 blocks array commits |
| sda_pull_o | output | 1 | 1 requests the data line to be pulled low |

## Verification
The bench builds the engine with ADDR_W=8, PAGE_W=4 and BUSY_CYC=300. This gives a 256-byte array in sixteen pages of sixteen bytes. Every page can then be written and the whole array read back in one sequential read that wraps past the top address. Page wrap, overflow past a page and acknowledge polling inside and after the busy window all fit in a short run. The short busy window lets the bench poll once during it and once after it. It also checks the write-protect and aborted-write cases against an arithmetic model of the array.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_AH, S_AL, S_WR, S_RD
  } twi_state_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_ff[1] & ~scl_q;
  assign scl_fall  = ~scl_ff[1] & scl_q;
  assign start_det = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
  assign stop_det  = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
endmodule

// File: rtl/twi_byte_ram.sv
module twi_byte_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twi_commit.sv
module twi_commit #(
  parameter int PAGE_W   = 6,
  parameter int BUSY_CYC = 5000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   go,
  input  logic [(1<<PAGE_W)-1:0] valid,
  output logic                   busy,
  output logic [PAGE_W-1:0]      buf_idx,
  output logic                   mem_we,
  output logic [PAGE_W-1:0]      mem_off
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int CW   = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cyc;

  assign buf_idx = cyc[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cyc     <= '0;
      mem_we  <= 1'b0;
      mem_off <= '0;
    end else begin
      mem_we <= 1'b0;
      if (go && !busy) begin
        busy <= 1'b1;
        cyc  <= '0;
      end else if (busy) begin
        cyc <= cyc + 1'b1;
        if (cyc == CW'(BUSY_CYC - 1)) busy <= 1'b0;
        if (cyc < CW'(PAGE)) begin
          mem_we  <= valid[cyc[PAGE_W-1:0]];
          mem_off <= cyc[PAGE_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 6,
  parameter int BUSY_CYC = 5000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wprot_i,
  output logic       sda_pull_o
);
  import twi_pkg::*;

  localparam int PAGE = 1 << PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  twi_state_t state, nxt;
  logic [3:0]        cnt;
  logic [7:0]        sh, addr_hi;
  logic [6:0]        tx;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE-1:0]   valid;
  logic              pull, mack, go, busy, busy_q;
  logic              buf_we, mem_we;
  logic [PAGE_W-1:0] buf_waddr, buf_idx, mem_off;
  logic [7:0]        buf_wdata, buf_rdata, arr_rdata;

  twi_line_sync sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_byte_ram #(.AW(PAGE_W)) page_buf_i (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_idx), .rdata(buf_rdata)
  );

  twi_byte_ram #(.AW(ADDR_W)) array_i (
    .clk(clk), .we(mem_we), .waddr({ptr[ADDR_W-1:PAGE_W], mem_off}),
    .wdata(buf_rdata), .raddr(ptr), .rdata(arr_rdata)
  );

  twi_commit #(.PAGE_W(PAGE_W), .BUSY_CYC(BUSY_CYC)) commit_i (
    .clk(clk), .rst(rst), .go(go), .valid(valid), .busy(busy),
    .buf_idx(buf_idx), .mem_we(mem_we), .mem_off(mem_off)
  );

  assign sda_pull_o = pull;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;  nxt <= S_IDLE;
      cnt <= '0;  sh <= '0;  tx <= '0;  addr_hi <= '0;  ptr <= '0;
      valid <= '0;  pull <= 1'b0;  mack <= 1'b0;  go <= 1'b0;  busy_q <= 1'b0;
      buf_we <= 1'b0;  buf_waddr <= '0;  buf_wdata <= '0;
    end else begin
      buf_we <= 1'b0;
      go     <= 1'b0;
      busy_q <= busy;
      if (busy_q && !busy) valid <= '0;
      if (start_det) begin
        state <= S_DEV;
        cnt   <= '0;
        pull  <= 1'b0;
        if (!busy) valid <= '0;
      end else if (stop_det) begin
        state <= S_IDLE;
        cnt   <= '0;
        pull  <= 1'b0;
        go    <= !busy && (|valid) && !wprot_i;
      end else if (state != S_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (cnt == 4'd8) begin
            cnt <= 4'd9;
            if (state == S_RD) mack <= !sda_s;
          end
        end else if (scl_fall) begin
          if (state == S_RD && cnt != 4'd9) begin
            if (cnt >= 4'd1 && cnt <= 4'd7) begin
              tx   <= {tx[5:0], 1'b0};
              pull <= !tx[6];
            end else if (cnt == 4'd8) begin
              pull <= 1'b0;
              nxt  <= S_RD;
            end
          end else if (cnt == 4'd8) begin
            case (state)
              S_DEV: begin
                if (sh[7:1] == {DEV_CODE, strap_i} && !busy) begin
                  pull <= 1'b1;
                  nxt  <= sh[0] ? S_RD : S_AH;
                end else begin
                  state <= S_IDLE;
                end
              end
              S_AH: begin
                pull    <= 1'b1;
                addr_hi <= sh;
                nxt     <= S_AL;
              end
              S_AL: begin
                pull <= 1'b1;
                ptr  <= ADDR_W'({addr_hi, sh});
                nxt  <= S_WR;
              end
              S_WR: begin
                pull      <= 1'b1;
                buf_we    <= 1'b1;
                buf_waddr <= ptr[PAGE_W-1:0];
                buf_wdata <= sh;
                valid[ptr[PAGE_W-1:0]] <= 1'b1;
                ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                nxt       <= S_WR;
              end
              default: state <= S_IDLE;
            endcase
          end else if (cnt == 4'd9) begin
            cnt  <= '0;
            pull <= 1'b0;
            if (state == S_RD && !mack) begin
              state <= S_IDLE;
            end else begin
              state <= nxt;
              if (nxt == S_RD) begin
                tx   <= arr_rdata[6:0];
                pull <= !arr_rdata[7];
                ptr  <= ptr + 1'b1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic pull,
  input logic mem_we,
  input logic start_det,
  input logic stop_det,
  input logic wprot,
  input logic scl_s
);
  // R7: no acknowledge or data is driven while the commit window runs
  p_silent_busy_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !pull);

  // R6: the array is written only inside a commit window
  p_write_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R1: bus events release the data line
  p_stop_release_r1: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !pull);
  p_start_release_r1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !pull);

  // R8: a protected stop never opens a commit window
  p_wp_no_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (stop_det && wprot && !busy) |=> ##1 !busy);

  // R12: the pull-down request only rises while SCL is low
  p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(pull) |-> !scl_s);
endmodule

bind twi_eeprom_slave twi_eeprom_chk chk_i (
  .clk(clk), .rst(rst), .busy(busy), .pull(sda_pull_o), .mem_we(mem_we),
  .start_det(start_det), .stop_det(stop_det), .wprot(wprot_i), .scl_s(scl_s)
);

// File: tb/twi_eeprom_slave_tb_top.sv
module twi_eeprom_slave_tb_top;
  localparam int AW = 8, PW = 4, BUSY = 300, H = 8;
  localparam int DEPTH = 1 << AW, PG = 1 << PW;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic pull, sda_bus;
  logic [7:0] model [DEPTH];
  int checks = 0, bad = 0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~pull;
  always #5 clk = ~clk;

  twi_eeprom_slave #(.ADDR_W(AW), .PAGE_W(PW), .BUSY_CYC(BUSY)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(strap), .wprot_i(wp), .sda_pull_o(pull)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int s);
    return 8'((a * 37 + s * 11 + 5) & 255);
  endfunction

  task automatic bus_start;
    sda_m = 1'b1; tick(H); scl = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(H); scl = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    put_bits(b, 8);
    sda_m = 1'b1; tick(H); scl = 1'b1; tick(H / 2);
    ack = !sda_bus;
    tick(H / 2); scl = 1'b0; tick(2);
  endtask

  task automatic get_byte(input bit ack_it, output logic [7:0] b);
    int unstable = 0;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl = 1'b1; tick(H / 2);
      b[i] = sda_bus;
      tick(H / 2 - 1);
      if (sda_bus != b[i]) unstable++;
      tick(1); scl = 1'b0; tick(2);
    end
    chk(unstable == 0, "R12 data stable while SCL high", unstable, 0);
    sda_m = ack_it ? 1'b0 : 1'b1; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] devb(input bit rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic header(input int addr);
    bit a;
    bus_start;
    put_byte(devb(1'b0), a); chk(a, "R2 select ack", a, 1);
    put_byte(8'hC0 | 8'(addr >> 8), a); chk(a, "R4 high address ack", a, 1);
    put_byte(8'(addr), a); chk(a, "R3 low address ack", a, 1);
  endtask

  task automatic write_seq(input int addr, input int n, input int s);
    bit a;
    header(addr);
    for (int k = 0; k < n; k++) begin
      int pa = (addr & ~(PG - 1)) | ((addr + k) & (PG - 1));
      put_byte(pat(pa + k, s), a); chk(a, "R3 data ack", a, 1);
      if (!wp) model[pa] = pat(pa + k, s);
    end
    bus_stop;
  endtask

  task automatic poll(output bit a);
    bus_start; put_byte(devb(1'b0), a); bus_stop;
  endtask

  task automatic read_from(input int addr, input int n, input string tag);
    bit a;
    logic [7:0] d;
    header(addr);
    bus_start;
    put_byte(devb(1'b1), a); chk(a, "R11 read select ack", a, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(k < n - 1, d);
      chk(d == model[(addr + k) % DEPTH], tag, d, model[(addr + k) % DEPTH]);
    end
    tick(4);
    chk(pull == 1'b0, "R10 released after NACK", pull, 0);
    bus_stop;
  endtask

  task automatic current_read(input int exp_addr, input string tag);
    bit a;
    logic [7:0] d;
    bus_start;
    put_byte(devb(1'b1), a); chk(a, "R9 read select ack", a, 1);
    get_byte(1'b0, d);
    chk(d == model[exp_addr], tag, d, model[exp_addr]);
    bus_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    tick(6); rst = 1'b0; tick(4);
    chk(pull == 1'b0, "R1 reset state", pull, 0);

    // R2: wrong strap and wrong code get no acknowledge
    bus_start; put_byte({4'b1010, strap ^ 3'b010, 1'b0}, a); bus_stop;
    chk(!a, "R2 strap mismatch nack", a, 0);
    bus_start; put_byte({4'b1011, strap, 1'b0}, a); bus_stop;
    chk(!a, "R2 code mismatch nack", a, 0);

    // fill every page; R7 polling around the first commit
    for (int p = 0; p < DEPTH / PG; p++) begin
      write_seq(p * PG, PG, 1);
      if (p == 0) begin
        poll(a); chk(!a, "R7 nack while busy", a, 0);
        tick(BUSY);
        poll(a); chk(a, "R7 ack after busy", a, 1);
      end else begin
        tick(BUSY + 20);
      end
    end

    // R9 R10 R11: whole array plus wrap to address 0
    read_from(0, DEPTH + 1, "R10 sequential read data");
    current_read(1, "R9 current address after wrap");

    // R5: page wrap and page overflow
    write_seq(8'h2E, 4, 2); tick(BUSY + 20);
    read_from(8'h20, PG, "R5 page wrap data");
    write_seq(8'h40, PG + 2, 3); tick(BUSY + 20);
    read_from(8'h40, PG, "R5 page overflow data");

    // R9: pointer after a write is last address plus one
    write_seq(8'h75, 1, 4); tick(BUSY + 20);
    current_read(8'h76, "R9 current address after write");

    // R8: write protect
    wp = 1'b1;
    write_seq(8'h10, 2, 5);
    poll(a); chk(a, "R8 no busy when protected", a, 1);
    wp = 1'b0;
    read_from(8'h10, 2, "R8 protected data unchanged");

    // R6: aborted write commits nothing
    header(8'h30); put_bits(8'hFF, 4); bus_stop;
    poll(a); chk(a, "R6 no busy after abort", a, 1);
    read_from(8'h30, 1, "R6 aborted data unchanged");

    // R1: start in the middle of a data byte aborts and restarts
    header(8'h50); put_bits(8'h00, 3);
    bus_start;
    put_byte(devb(1'b1), a); chk(a, "R1 select after mid-byte start", a, 1);
    get_byte(1'b0, d);
    chk(d == model[8'h50], "R1 read after mid-byte start", d, model[8'h50]);
    bus_stop;
    tick(BUSY);
    poll(a); chk(a, "R1 nothing committed by mid-byte start", a, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule